// File: doc/BRIEF.md
# Sampled Port Level-Change Interrupt Detector

This block watches a small input port and raises one shared interrupt whenever the combined activity of its enabled pins changes state. Each pin has an enable bit and a mode bit. Mode 0 treats a high pin as active and mode 1 treats a low pin as active. The enabled pins, after this polarity step, are ORed into one activity level. That level is sampled only on the falling edge of a slow time-base tap. Software picks either the slow (128 Hz) tap or the fast (4 kHz) tap with a select bit.

When a sample differs from the previous one, the block emits a one-clock request pulse and sets a sticky flag. Software clears the flag with a write strobe. Because one interrupt serves every pin, the block does not say which pin caused it, and software reads the port to find out. The block also drives a constant vector address to the priority logic.

Raw pins and both taps enter through multi-stage synchronisers into the system clock domain. The sampling strobe is a one-cycle pulse derived from the selected tap in that domain.

Top module: `pin_change_irq`

## Requirements
- R1: A pin whose enable bit is 0 never affects the activity level, so toggling it alone never produces a request.
- R2: With mode bit 0 a pin is active when high; with mode bit 1 it is active when low.
- R3: The level is sampled only on a falling edge of the tap chosen by `tap_sel_i` (0 = slow tap, 1 = fast tap). Rising edges, edges of the unselected tap, and pin changes between strobes produce no request. A tap edge seen in the cycle the select changes is discarded.
- R4: While no enabled pin is active, a request fires at the first strobe after any enabled pin becomes active.
- R5: While some enabled pin is active, no request fires as long as any enabled pin stays active. A request fires at the first strobe after all enabled pins have become inactive.
- R6: A request is a single-clock high pulse on `irq_req_o`. It appears on the third rising clock edge after the selected tap falls, with pins stable for at least two clocks before that fall.
- R7: `irq_flag_o` rises together with a request pulse. It stays high until a clock edge at which `flag_clr_i` is 1, and then reads 0.
- R8: If a request and `flag_clr_i` coincide on the same edge, the flag is set.
- R9: After reset, `irq_flag_o` and `irq_req_o` are 0. Pins that are already active during reset produce no request at the first strobe.
- R10: `irq_vec_o` always carries the vector address 0x0016.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Raw port pins (asynchronous) |
| pin_en_i | input | NPINS | Per-pin enable, 1 = pin takes part |
| pin_mode_i | input | NPINS | Per-pin polarity, 1 = active low |
| tb_slow_i | input | 1 | Slow time-base tap (128 Hz) |
| tb_fast_i | input | 1 | Fast time-base tap (4 kHz) |
| tap_sel_i | input | 1 | Tap select, 0 = slow, 1 = fast |
| flag_clr_i | input | 1 | Flag clear write strobe |
| irq_req_o | output | 1 | One-clock interrupt request pulse |
| irq_flag_o | output | 1 | Sticky interrupt request flag |
| irq_vec_o | output | VEC_W | Constant interrupt vector address |

## Verification
The bench builds the block with its defaults: four pins, two synchroniser stages and a 16-bit vector. Two stages fix the tap-to-request latency at three clocks, so every expected pulse can be pinned to one exact cycle and every other cycle checked for silence. The bench drives both taps directly as slow square waves at its own pace, which puts both tap selections and their ignored edges within a few thousand clocks. Four pins are few enough for the random mix of enables, modes and levels to reach every polarity combination, and the set-versus-clear collision.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

  // Tap choice; the encoding matches the tap_sel_i port.
  typedef enum logic {
    TAP_SLOW = 1'b0,
    TAP_FAST = 1'b1
  } tap_sel_e;

  localparam int unsigned DEF_NPINS       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_VEC_W       = 16;
  localparam logic [15:0] DEF_VECTOR      = 16'h0016;

endpackage

// File: rtl/pci_sync.sv
// Multi-stage synchroniser; no reset so the chain is a plain shift path.
module pci_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/pci_tap_strobe.sv
// Selects a time-base tap and turns its falling edge into a one-clock strobe.
module pci_tap_strobe
  import pin_change_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_i,
  input  logic fast_i,
  input  logic sel_i,
  output logic strobe_o
);

  logic [1:0] taps_s;
  logic       tap_now;
  logic       tap_q;
  logic       sel_q;
  tap_sel_e   sel_e;

  pci_sync #(.W(2), .STAGES(SYNC_STAGES)) u_tap_sync (
    .clk (clk),
    .d_i ({fast_i, slow_i}),
    .q_o (taps_s)
  );

  assign sel_e   = tap_sel_e'(sel_i);
  assign tap_now = (sel_e == TAP_FAST) ? taps_s[1] : taps_s[0];

  always_ff @(posedge clk) begin
    tap_q <= tap_now;
    sel_q <= sel_i;
  end

  // Falling edge of the chosen tap; dropped during reset or a select change.
  assign strobe_o = !rst && (sel_q == sel_i) && tap_q && !tap_now;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o); // R3

endmodule

// File: rtl/pci_level.sv
// Polarity adjustment, enable masking and OR reduction of the port pins.
module pci_level #(
  parameter int unsigned NPINS = 4
) (
  input  logic [NPINS-1:0] pin_s_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] mode_i,
  output logic             level_o
);

  logic [NPINS-1:0] act;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // mode 1: active low, so invert before combining
    assign act[i] = en_i[i] & (pin_s_i[i] ^ mode_i[i]);
  end

  assign level_o = |act;

endmodule

// File: rtl/pci_change_det.sv
// Holds the last sampled level and flags a change at each strobe.
module pci_change_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  input  logic level_i,
  output logic hit_o,
  output logic pulse_o
);

  logic prev_q;

  assign hit_o = strobe_i && (level_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= level_i;   // seed from live level: no spurious request
      pulse_o <= 1'b0;
    end else begin
      if (strobe_i) prev_q <= level_i;
      pulse_o <= hit_o;
    end
  end

  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(strobe_i)); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R6

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int unsigned NPINS       = DEF_NPINS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned VEC_W       = DEF_VEC_W,
  parameter logic [VEC_W-1:0] VECTOR = VEC_W'(DEF_VECTOR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pin_en_i,
  input  logic [NPINS-1:0] pin_mode_i,
  input  logic             tb_slow_i,
  input  logic             tb_fast_i,
  input  logic             tap_sel_i,
  input  logic             flag_clr_i,
  output logic             irq_req_o,
  output logic             irq_flag_o,
  output logic [VEC_W-1:0] irq_vec_o
);

  logic [NPINS-1:0] pin_s;
  logic             level;
  logic             strobe;
  logic             hit;

  pci_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk (clk),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  pci_level #(.NPINS(NPINS)) u_level (
    .pin_s_i (pin_s),
    .en_i    (pin_en_i),
    .mode_i  (pin_mode_i),
    .level_o (level)
  );

  pci_tap_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_tap (
    .clk      (clk),
    .rst      (rst),
    .slow_i   (tb_slow_i),
    .fast_i   (tb_fast_i),
    .sel_i    (tap_sel_i),
    .strobe_o (strobe)
  );

  pci_change_det u_det (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe),
    .level_i  (level),
    .hit_o    (hit),
    .pulse_o  (irq_req_o)
  );

  // Sticky flag: set has priority over the software clear.
  always_ff @(posedge clk) begin
    if (rst)             irq_flag_o <= 1'b0;
    else if (hit)        irq_flag_o <= 1'b1;
    else if (flag_clr_i) irq_flag_o <= 1'b0;
  end

  assign irq_vec_o = VECTOR;

  AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> irq_flag_o); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R7
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag_o) |-> irq_req_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit && flag_clr_i) |=> irq_flag_o); // R8

endmodule

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin = 4'b0001;
  logic [3:0] en  = 4'b0001;
  logic [3:0] mode = 4'b0000;
  logic       slow = 1'b0;
  logic       fast = 1'b0;
  logic       sel  = 1'b0;
  logic       clr  = 1'b0;
  logic       req;
  logic       flag;
  logic [15:0] vec;

  int checks = 0;
  int errors = 0;
  logic m_prev;
  logic m_flag;

  always #10 clk = ~clk;

  pin_change_irq u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .pin_en_i(en), .pin_mode_i(mode),
    .tb_slow_i(slow), .tb_fast_i(fast), .tap_sel_i(sel), .flag_clr_i(clr),
    .irq_req_o(req), .irq_flag_o(flag), .irq_vec_o(vec)
  );

  function automatic logic summ(logic [3:0] p, logic [3:0] e, logic [3:0] m);
    return |((p ^ m) & e);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge. Raises the selected tap, waits, drops it, checks the result.
  task automatic tap_cycle(string tag, bit clr_at_set);
    logic exp;
    if (sel) fast = 1'b1; else slow = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (sel) slow = ~slow; else fast = ~fast;   // unselected tap wiggles
      check({tag, " R3 no req without selected fall"}, req, 1'b0);
    end
    if (sel) fast = 1'b0; else slow = 1'b0;
    exp = summ(pin, en, mode) != m_prev;
    m_prev = summ(pin, en, mode);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({tag, " R6 no early req"}, req, 1'b0);
    clr = clr_at_set;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    m_flag = exp | (m_flag & ~clr_at_set);
    check({tag, " R6 req at third edge"}, req, exp);
    check({tag, " R7 R8 flag"}, flag, m_flag);
    @(negedge clk);
    check({tag, " R6 req one cycle"}, req, 1'b0);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_flag = 1'b0;
    check("R7 flag cleared", flag, 1'b0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R9: pin 0 already active through reset
    repeat (6) @(negedge clk);
    rst = 1'b0;
    m_prev = 1'b1;
    m_flag = 1'b0;
    check("R9 flag after reset", flag, 1'b0);
    check("R9 req after reset", req, 1'b0);
    check("R10 vector", vec, 16'h0016);
    tap_cycle("R9 no spurious", 1'b0);
    check("R9 no spurious flag", flag, 1'b0);

    // R5: second pin goes active then first drops: still active, no request
    en = 4'b0011; pin = 4'b0011; settle();
    tap_cycle("R5 still active", 1'b0);
    pin = 4'b0010; settle();
    tap_cycle("R5 one left", 1'b0);
    check("R5 no req while any active", flag, 1'b0);
    pin = 4'b0000; settle();
    tap_cycle("R5 all inactive", 1'b0);
    check("R5 fired", flag, 1'b1);
    clear_flag();

    // R1: disabled pin toggles without effect
    en = 4'b0001; pin = 4'b1000; settle();
    tap_cycle("R1 disabled pin", 1'b0);
    check("R1 no flag", flag, 1'b0);

    // R4 + R2: active-low pin 2 pulled low
    en = 4'b0100; mode = 4'b0100; pin = 4'b0100; settle();
    tap_cycle("R2 high is idle", 1'b0);
    check("R2 no flag while high", flag, 1'b0);
    pin = 4'b0000; settle();
    tap_cycle("R4 R2 low activates", 1'b0);
    check("R4 fired", flag, 1'b1);

    // R8: clear collides with a set, using the fast tap (R3)
    sel = 1'b1; settle();
    clear_flag();
    pin = 4'b0100; settle();
    tap_cycle("R8 collision fast tap", 1'b1);
    check("R8 set wins", flag, 1'b1);
    clear_flag();

    // Random mix
    for (int k = 0; k < 60; k++) begin
      pin  = 4'($urandom);
      if ($urandom % 3 == 0) en = 4'($urandom);
      if ($urandom % 3 == 0) mode = 4'($urandom);
      if ($urandom % 5 == 0) begin
        sel = 1'($urandom);
        settle();
      end
      settle();
      tap_cycle("R3 R4 R5 random", ($urandom % 4) == 0);
      if ($urandom % 3 == 0) clear_flag();
    end
    check("R10 vector end", vec, 16'h0016);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule